// File: doc/BRIEF.md
# Perturbation Learning Sequencer

This block is the phase controller for a recurrent network that is evaluated one neuron at a time and trained by simultaneous perturbation, a gradient-free method. Each learning iteration needs two error evaluations. The first run uses the current weights. The second run uses the same weights after every one of them has been nudged by a random sign at the same time. The update unit then changes every weight using only those two error figures. No error is propagated backwards.

The sequencer launches a loader, a neuron engine, an error accumulator, a perturbation unit and an update unit, one at a time. Each launch is a single-cycle start strobe. The sequencer then waits for the matching single-cycle done pulse before it moves to the next phase. It stores the error reported at the end of each evaluation and hands both values to the update unit. It decides after every unperturbed evaluation whether learning has converged. It also stops learning once a programmable number of iterations has completed. In pattern-embedding use, the loader places the desired pattern in the network state and the neuron engine performs a single network update before the error is measured. The sequencer records that mode once, when the loader is launched.

Top module: `pert_learn_seq`

## Requirements
- R1: While rst_ni is low, phase_o is 0 (Init), every start strobe is low, finished_o is low and iter_o is 0. The first strobe issued after reset release is init_start_o.
- R2: The phase codes on phase_o are Init=0, Run1=1, Error1=2, Check=3, Perturb=4, Run2=5, Error2=6, Modify=7 and Finished=8. The phases run in the order Init, Run1, Error1, Check, Perturb, Run2, Error2, Modify, and Modify returns to Run1. Init, Run1 and Run2 are left only on a done pulse. Error1 and Error2 are left only on a done pulse. Perturb and Modify are left only on a done pulse. Check is left after one cycle.
- R3: A start strobe is high for exactly the first cycle of its phase. At most one strobe is high in any cycle. The strobes map to phases as follows: init_start_o for Init, run_start_o for Run1 and Run2, err_start_o for Error1 and Error2, pert_start_o for Perturb, and upd_start_o for Modify.
- R4: A done pulse is accepted only when it comes from the unit of the current phase, and only in a cycle after that unit's start strobe. A done pulse from any other unit, or one that coincides with the start strobe, leaves the phase unchanged.
- R5: When the done pulse that ends Error1 is accepted, err_i is captured into err1_o. When the done pulse that ends Error2 is accepted, err_i is captured into err2_o. Each value is held until its next capture.
- R6: In Check, learning ends with converged_o high when err1_o is strictly less than thresh_i. An error equal to the threshold continues to Perturb.
- R7: iter_o counts completed iterations. It increments by one when the done pulse that ends Modify is accepted, and it changes at no other time.
- R8: When Check does not find convergence and iter_o is at least max_iter_i, learning ends with timeout_o high and no Perturb strobe. Convergence takes priority, and converged_o and timeout_o are never both high.
- R9: Once in Finished, finished_o stays high and no strobe is issued until reset. In Finished, done pulses change neither the stored errors nor iter_o.
- R10: run_oneshot_o takes the value of embed_i in the cycle init_start_o is issued. Later changes of embed_i do not affect it before the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| embed_i | input | 1 | Pattern-embedding mode request, sampled at Init launch |
| err_i | input | EW | Error value from the accumulator, valid with err_done_i |
| thresh_i | input | EW | Convergence threshold |
| max_iter_i | input | IW | Iteration limit |
| init_done_i | input | 1 | Loader finished |
| run_done_i | input | 1 | Neuron engine finished a run |
| err_done_i | input | 1 | Error accumulator finished |
| pert_done_i | input | 1 | Perturbation applied to all weights |
| upd_done_i | input | 1 | Weight update finished |
| init_start_o | output | 1 | Launch loader |
| run_start_o | output | 1 | Launch neuron engine |
| err_start_o | output | 1 | Launch error accumulator |
| pert_start_o | output | 1 | Launch perturbation unit |
| upd_start_o | output | 1 | Launch weight update unit |
| run_oneshot_o | output | 1 | Neuron engine performs a single update per run |
| phase_o | output | 4 | Current phase code |
| err1_o | output | EW | Unperturbed error |
| err2_o | output | EW | Perturbed error |
| iter_o | output | IW | Completed iterations |
| finished_o | output | 1 | Learning ended |
| converged_o | output | 1 | Ended by threshold |
| timeout_o | output | 1 | Ended by iteration limit |

## Verification
The first pattern runs in embedding mode with errors that fall over two full iterations and then drop below the threshold. It shows the complete phase order, the capture of both errors, the iteration count and the held mode. The second pattern uses an error exactly equal to the threshold and a limit of two iterations. It separates the strict comparison from a non-strict one and shows that the limit stops learning before another perturbation. The same pattern injects done pulses from idle units and on the start cycle, to separate a gated handshake from an ungated one. Two runs with a limit of zero, one with the error below the threshold and one above it, show which exit condition takes priority. Done pulses after learning ends show that the terminal state is sticky.

// File: rtl/pls_pkg.sv
package pls_pkg;

  typedef enum logic [3:0] {
    PH_INIT   = 4'd0,
    PH_RUN1   = 4'd1,
    PH_ERR1   = 4'd2,
    PH_CHECK  = 4'd3,
    PH_PERT   = 4'd4,
    PH_RUN2   = 4'd5,
    PH_ERR2   = 4'd6,
    PH_MODIFY = 4'd7,
    PH_DONE   = 4'd8
  } phase_e;

  localparam int NUM_UNITS = 5;

  typedef enum logic [2:0] {
    U_INIT = 3'd0,
    U_RUN  = 3'd1,
    U_ERR  = 3'd2,
    U_PERT = 3'd3,
    U_UPD  = 3'd4,
    U_NONE = 3'd5
  } unit_e;

  function automatic unit_e unit_of(input phase_e p);
    case (p)
      PH_INIT:           return U_INIT;
      PH_RUN1, PH_RUN2:  return U_RUN;
      PH_ERR1, PH_ERR2:  return U_ERR;
      PH_PERT:           return U_PERT;
      PH_MODIFY:         return U_UPD;
      default:           return U_NONE;
    endcase
  endfunction

  // successor of a handshaked phase; Check is resolved separately
  function automatic phase_e phase_after(input phase_e p);
    case (p)
      PH_INIT:   return PH_RUN1;
      PH_RUN1:   return PH_ERR1;
      PH_ERR1:   return PH_CHECK;
      PH_PERT:   return PH_RUN2;
      PH_RUN2:   return PH_ERR2;
      PH_ERR2:   return PH_MODIFY;
      PH_MODIFY: return PH_RUN1;
      default:   return p;
    endcase
  endfunction

endpackage

// File: rtl/pls_phase_fsm.sv
module pls_phase_fsm
  import pls_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_UNITS-1:0] done_i,
  input  logic                 below_i,
  input  logic                 at_limit_i,
  output phase_e               phase_o,
  output logic [NUM_UNITS-1:0] start_o,
  output logic                 accept_o,
  output logic                 fin_o,
  output logic                 conv_o,
  output logic                 tout_o
);

  phase_e state_q, state_d;
  logic   active_q, issued_q, issued_d;
  logic   conv_q, conv_d, tout_q, tout_d;
  unit_e  cur_u;
  logic [NUM_UNITS-1:0] sel;
  logic   launch, accept;

  assign cur_u = unit_of(state_q);

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_sel
    assign sel[g] = (cur_u == unit_e'(g));
  end

  // strobe on the first active cycle of a handshaked phase
  assign launch  = active_q && !issued_q && (|sel);
  assign start_o = sel & {NUM_UNITS{launch}};
  // only the current unit's done, and only once it has been launched
  assign accept  = issued_q && (|(done_i & sel));

  always_comb begin
    state_d  = state_q;
    issued_d = issued_q;
    conv_d   = conv_q;
    tout_d   = tout_q;
    if (launch) issued_d = 1'b1;
    if (accept) begin
      issued_d = 1'b0;
      state_d  = phase_after(state_q);
    end
    if (state_q == PH_CHECK) begin
      if (below_i) begin
        state_d = PH_DONE;
        conv_d  = 1'b1;
      end else if (at_limit_i) begin
        state_d = PH_DONE;
        tout_d  = 1'b1;
      end else begin
        state_d = PH_PERT;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= PH_INIT;
      active_q <= 1'b0;
      issued_q <= 1'b0;
      conv_q   <= 1'b0;
      tout_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      active_q <= 1'b1;
      issued_q <= issued_d;
      conv_q   <= conv_d;
      tout_q   <= tout_d;
    end
  end

  assign phase_o  = state_q;
  assign accept_o = accept;
  assign fin_o    = (state_q == PH_DONE);
  assign conv_o   = conv_q;
  assign tout_o   = tout_q;

endmodule

// File: rtl/pls_err_capture.sv
module pls_err_capture #(
  parameter int EW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    we_i,
  input  logic [EW-1:0] err_i,
  input  logic [EW-1:0] thresh_i,
  output logic [EW-1:0] err1_o,
  output logic [EW-1:0] err2_o,
  output logic          below_o
);

  localparam int SLOTS = 2;

  logic [EW-1:0] slot_q [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      slot_q[g] <= '0;
      else if (we_i[g]) slot_q[g] <= err_i;
    end
  end

  assign err1_o  = slot_q[0];
  assign err2_o  = slot_q[1];
  assign below_o = (slot_q[0] < thresh_i);

endmodule

// File: rtl/pls_iter_cnt.sv
module pls_iter_cnt #(
  parameter int IW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic [IW-1:0] max_i,
  output logic [IW-1:0] cnt_o,
  output logic          at_max_o
);

  localparam logic [IW-1:0] CNT_TOP = {IW{1'b1}};

  logic [IW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (inc_i && cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o    = cnt_q;
  assign at_max_o = (cnt_q >= max_i);

endmodule

// File: rtl/pert_learn_seq.sv
module pert_learn_seq
  import pls_pkg::*;
#(
  parameter int EW = 16,
  parameter int IW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          embed_i,
  input  logic [EW-1:0] err_i,
  input  logic [EW-1:0] thresh_i,
  input  logic [IW-1:0] max_iter_i,
  input  logic          init_done_i,
  input  logic          run_done_i,
  input  logic          err_done_i,
  input  logic          pert_done_i,
  input  logic          upd_done_i,
  output logic          init_start_o,
  output logic          run_start_o,
  output logic          err_start_o,
  output logic          pert_start_o,
  output logic          upd_start_o,
  output logic          run_oneshot_o,
  output logic [3:0]    phase_o,
  output logic [EW-1:0] err1_o,
  output logic [EW-1:0] err2_o,
  output logic [IW-1:0] iter_o,
  output logic          finished_o,
  output logic          converged_o,
  output logic          timeout_o
);

  logic [NUM_UNITS-1:0] done_vec, start_vec;
  phase_e phase;
  logic   accept, below, at_limit, mode_q;
  logic [1:0] cap_we;

  assign done_vec = {upd_done_i, pert_done_i, err_done_i, run_done_i, init_done_i};

  pls_phase_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_i     (done_vec),
    .below_i    (below),
    .at_limit_i (at_limit),
    .phase_o    (phase),
    .start_o    (start_vec),
    .accept_o   (accept),
    .fin_o      (finished_o),
    .conv_o     (converged_o),
    .tout_o     (timeout_o)
  );

  assign cap_we = {accept && (phase == PH_ERR2), accept && (phase == PH_ERR1)};

  pls_err_capture #(.EW(EW)) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cap_we),
    .err_i    (err_i),
    .thresh_i (thresh_i),
    .err1_o   (err1_o),
    .err2_o   (err2_o),
    .below_o  (below)
  );

  pls_iter_cnt #(.IW(IW)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (accept && (phase == PH_MODIFY)),
    .max_i    (max_iter_i),
    .cnt_o    (iter_o),
    .at_max_o (at_limit)
  );

  // mode is fixed for the whole learning session
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   mode_q <= 1'b0;
    else if (start_vec[U_INIT])    mode_q <= embed_i;
  end

  assign init_start_o  = start_vec[U_INIT];
  assign run_start_o   = start_vec[U_RUN];
  assign err_start_o   = start_vec[U_ERR];
  assign pert_start_o  = start_vec[U_PERT];
  assign upd_start_o   = start_vec[U_UPD];
  assign run_oneshot_o = mode_q;
  assign phase_o       = phase;

endmodule

// File: rtl/pls_chk.sv
module pls_chk #(
  parameter int EW = 16,
  parameter int IW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [4:0]    stb_i,
  input logic [3:0]    phase_i,
  input logic [EW-1:0] err1_i,
  input logic [EW-1:0] thresh_i,
  input logic [IW-1:0] iter_i,
  input logic [IW-1:0] max_i,
  input logic          fin_i,
  input logic          conv_i,
  input logic          tout_i
);

  p_stb_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(stb_i));

  p_stb_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|stb_i) |=> !(|stb_i));

  p_run1_next_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == 4'd1) |=> (phase_i == 4'd1 || phase_i == 4'd2));

  p_check_next_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == 4'd3) |=> (phase_i == 4'd4 || phase_i == 4'd8));

  p_modify_next_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == 4'd7) |=> (phase_i == 4'd7 || phase_i == 4'd1));

  p_iter_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i != 4'd7) |=> $stable(iter_i));

  p_conv_thresh_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_i) |-> (err1_i < thresh_i));

  p_flags_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(conv_i && tout_i));

  p_tout_limit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tout_i |-> (iter_i >= max_i));

  p_fin_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_i |=> (fin_i && $stable(iter_i) && $stable(err1_i)));

  p_fin_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_i |-> (stb_i == 5'd0));

endmodule

bind pert_learn_seq pls_chk #(.EW(EW), .IW(IW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .stb_i    ({upd_start_o, pert_start_o, err_start_o, run_start_o, init_start_o}),
  .phase_i  (phase_o),
  .err1_i   (err1_o),
  .thresh_i (thresh_i),
  .iter_i   (iter_o),
  .max_i    (max_iter_i),
  .fin_i    (finished_o),
  .conv_i   (converged_o),
  .tout_i   (timeout_o)
);

// File: tb/sim_pert_learn_seq.sv
`timescale 1ns/1ps
module sim_pert_learn_seq;
  localparam int EW = 16;
  localparam int IW = 8;

  logic clk = 1'b0, rst_n = 1'b0, embed = 1'b0;
  logic [EW-1:0] err_v = '0, thr = '0;
  logic [IW-1:0] maxi = '0;
  logic [4:0] dn = '0;
  logic init_s, run_s, err_s, pert_s, upd_s, oneshot, fin, conv, tout;
  logic [3:0] phase;
  logic [EW-1:0] e1, e2;
  logic [IW-1:0] iter;
  logic [4:0] stb;

  int n_chk = 0, n_err = 0;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  pert_learn_seq #(.EW(EW), .IW(IW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .embed_i(embed), .err_i(err_v), .thresh_i(thr),
    .max_iter_i(maxi), .init_done_i(dn[0]), .run_done_i(dn[1]), .err_done_i(dn[2]),
    .pert_done_i(dn[3]), .upd_done_i(dn[4]), .init_start_o(init_s), .run_start_o(run_s),
    .err_start_o(err_s), .pert_start_o(pert_s), .upd_start_o(upd_s),
    .run_oneshot_o(oneshot), .phase_o(phase), .err1_o(e1), .err2_o(e2), .iter_o(iter),
    .finished_o(fin), .converged_o(conv), .timeout_o(tout)
  );

  assign stb = {upd_s, pert_s, err_s, run_s, init_s};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int id_of(input logic [4:0] s);
    for (int i = 0; i < 5; i++) if (s[i]) return i;
    return 15;
  endfunction

  // monitor: every strobe must match the next expected {unit, phase}
  initial forever begin
    @(negedge clk);
    #0.5;
    if (rst_n) begin
      if ($countones(stb) > 1) chk(0, "R3 strobes not exclusive", int'(stb), 0);
      else if (stb != 0) begin
        if (exp_q.size() == 0) chk(0, "R2 unexpected strobe", int'({4'(id_of(stb)), phase}), 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk({4'(id_of(stb)), phase} == e, "R2 R3 strobe and phase", int'({4'(id_of(stb)), phase}), int'(e));
        end
      end
    end
  end

  task automatic serve(input int id, input int ph, input int lat, input logic [EW-1:0] ev);
    exp_q.push_back({4'(id), 4'(ph)});
    while (!stb[id]) @(negedge clk);
    repeat (lat) @(negedge clk);
    dn[id] = 1'b1;
    err_v  = ev;
    @(negedge clk);
    dn = '0;
  endtask

  task automatic iter_full(input logic [EW-1:0] ea, input logic [EW-1:0] eb);
    serve(1, 1, 2, 0);
    serve(2, 2, 1, ea);
    serve(3, 4, 2, 0);
    serve(1, 5, 1, 0);
    serve(2, 6, 3, eb);
    serve(4, 7, 2, 0);
  endtask

  task automatic do_reset(input bit emb, input int th, input int mx);
    rst_n = 1'b0; dn = '0; embed = emb; thr = EW'(th); maxi = IW'(mx);
    exp_q.delete();
    repeat (3) @(negedge clk);
    chk(phase == 4'd0 && stb == 0 && !fin && iter == 0, "R1 reset state",
        int'({fin, stb, phase}), 0);
    rst_n = 1'b1;
    serve(0, 0, 2, 0);
  endtask

  task automatic finish_wait();
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2 pending expected strobes", exp_q.size(), 0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    // S1: embedding mode, converges after two iterations
    do_reset(1'b1, 100, 10);
    chk(oneshot == 1'b1, "R10 mode latched at init", oneshot, 1);
    embed = 1'b0;
    iter_full(500, 480);
    chk(e1 == 500, "R5 err1 capture", e1, 500);
    chk(e2 == 480, "R5 err2 capture", e2, 480);
    chk(iter == 1, "R7 iteration count", iter, 1);
    iter_full(300, 290);
    chk(iter == 2, "R7 iteration count", iter, 2);
    chk(e2 == 290, "R5 err2 recapture", e2, 290);
    serve(1, 1, 1, 0);
    serve(2, 2, 2, 99);
    finish_wait();
    chk(fin && conv && !tout, "R6 converged below threshold", int'({fin, conv, tout}), 6);
    chk(phase == 4'd8, "R2 finished phase code", phase, 8);
    chk(iter == 2, "R7 no count on exit", iter, 2);
    chk(oneshot == 1'b1, "R10 mode unaffected by embed change", oneshot, 1);
    dn = 5'b11111; err_v = 16'd5;
    @(negedge clk);
    dn = '0;
    repeat (3) @(negedge clk);
    chk(fin && phase == 4'd8, "R9 finished sticky", int'({fin, phase}), 24);
    chk(e1 == 99 && e2 == 290, "R9 errors untouched when finished", e1, 99);
    chk(iter == 2, "R9 count untouched when finished", iter, 2);

    // S2: threshold equality, stray dones, iteration limit
    do_reset(1'b0, 100, 2);
    chk(oneshot == 1'b0, "R10 normal mode latched", oneshot, 0);
    exp_q.push_back({4'd1, 4'd1});
    while (!stb[1]) @(negedge clk);
    dn = 5'b11010;
    @(negedge clk);
    dn = '0;
    repeat (2) @(negedge clk);
    chk(phase == 4'd1, "R4 done on start cycle ignored", phase, 1);
    dn = 5'b11001;
    @(negedge clk);
    dn = '0;
    repeat (2) @(negedge clk);
    chk(phase == 4'd1, "R4 foreign dones ignored", phase, 1);
    dn[1] = 1'b1;
    @(negedge clk);
    dn = '0;
    serve(2, 2, 1, 100);
    serve(3, 4, 1, 0);
    serve(1, 5, 1, 0);
    serve(2, 6, 1, 120);
    serve(4, 7, 1, 0);
    chk(iter == 1 && !fin, "R6 equal error does not converge", int'(iter), 1);
    iter_full(150, 140);
    serve(1, 1, 1, 0);
    serve(2, 2, 1, 150);
    finish_wait();
    chk(fin && tout && !conv, "R8 timeout at limit", int'({fin, conv, tout}), 5);
    chk(iter == 2, "R8 iterations at timeout", iter, 2);

    // S3: zero limit but error below threshold: convergence wins
    do_reset(1'b0, 50, 0);
    serve(1, 1, 1, 0);
    serve(2, 2, 1, 10);
    finish_wait();
    chk(conv && !tout, "R8 convergence priority", int'({conv, tout}), 2);

    // S4: zero limit, error above threshold
    do_reset(1'b0, 50, 0);
    serve(1, 1, 1, 0);
    serve(2, 2, 1, 60);
    finish_wait();
    chk(tout && !conv && iter == 0, "R8 immediate timeout", int'({conv, tout}), 1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule